// File: doc/BRIEF.md
# Interrupt Status, Enable and Clear Register Block

This block gathers interrupt events from a storage bus controller core and turns them into a single registered interrupt request. Single-cycle event pulses set sticky status bits. A per-bit enable register chooses which bus-side status bits count toward the interrupt. The host clears bits by writing ones to dedicated clear registers. The host reaches all of this through a generic byte-wide register port: address, write strobe, write data, and a read data path that responds in the same cycle.

A separate sequencer-side port posts an event. Each post sets a sequencer flag and places a 4-bit event code in the upper nibble of the summary status register. The values used are 0x1 for a refused message, 0x3 for a reconnect with no matching command, 0x8 for a nonzero residual count, 0xE for an overrun, and 0x0 for an unrecognised bus phase.

The pending output is the OR of four interrupt classes: breakpoint, sequencer, bus, and command complete. Catastrophic errors are latched in a separate hard-error register. That register ignores every host clear and empties only on reset.

Top module: `intr_stat_ctl`

## Requirements
- R1: While `rstN` is low, and after it is released, every register reads 0 and `irq` and `intPending` are low.
- R2: A one-cycle pulse on bit i of `scsiEvt` sets bit i of the bus status register (address 2). The bit stays set until it is cleared.
- R3: Writing to address 3 clears each bus status bit whose write-data bit is 1. Bits written with 0 are left unchanged. Address 3 reads 0.
- R4: Address 4 is a read/write bus enable register. Bit 2 of the summary register (address 0) reads as the OR over all bits of (bus status AND bus enable).
- R5: A `seqPost` pulse sets bit 0 of address 0 and loads `seqCodeIn` into bits 7:4. A later post overwrites the code. Code 0 with the flag set is a valid report (unknown bus phase). Host writes to address 0 have no effect.
- R6: Writing to address 1 clears by write-one. Bit 0 clears the sequencer flag and zeroes the code field. Bit 1 clears command complete. Bit 3 clears breakpoint. Bit 2, and any bit written 0, has no effect.
- R7: When an event arrives in the same cycle as a host clear of the same bit, the event wins and the bit stays set. This covers sequencer posts, bus events, command complete and breakpoint.
- R8: `intPending` is the OR of breakpoint (bit 3), sequencer flag (bit 0), bus interrupt (bit 2) and command complete (bit 1). `irq` is registered: it equals `intPending` OR any hard-error bit, one clock later.
- R9: A pulse on `hardEvt` bit i sets bit i of the hard-error register (address 5). Host writes never clear it; only reset does. Any set hard-error bit holds `irq` high.
- R10: A `cmdEvt` pulse sets bit 1 of address 0, and a `brkEvt` pulse sets bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Register address |
| hostWe | input | 1 | Write strobe |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data for hostAddr (combinational) |
| scsiEvt | input | 8 | Bus event pulses |
| cmdEvt | input | 1 | Command complete pulse |
| brkEvt | input | 1 | Breakpoint pulse |
| seqPost | input | 1 | Sequencer interrupt post pulse |
| seqCodeIn | input | 4 | Event code posted with seqPost |
| hardEvt | input | 8 | Catastrophic error pulses |
| intPending | output | 1 | OR of the four interrupt classes |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every event input is a synchronous pulse sampled on the rising edge. They also assume that `seqCodeIn` is valid in the cycle `seqPost` is high, and that reset is held for at least one edge. The stimulus changes inputs only on falling edges and drops each pulse after one cycle. It also deliberately lines up event pulses with clear writes to exercise the priority rule. Checks sample the outputs one edge after a state change to read the registered `irq`.

// File: rtl/intr_stat_pkg.sv
package intr_stat_pkg;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 3;

  // register addresses
  localparam logic [2:0] A_INT   = 3'd0;
  localparam logic [2:0] A_ICLR  = 3'd1;
  localparam logic [2:0] A_SSTAT = 3'd2;
  localparam logic [2:0] A_SCLR  = 3'd3;
  localparam logic [2:0] A_SEN   = 3'd4;
  localparam logic [2:0] A_HERR  = 3'd5;

  // summary register bit positions
  localparam int B_SEQ  = 0;
  localparam int B_CMD  = 1;
  localparam int B_SCSI = 2;
  localparam int B_BRK  = 3;

  typedef struct packed {
    logic intClrWr;
    logic scsiClrWr;
    logic enWr;
    logic [2:0] rdSel;
  } strobe_t;
endpackage

// File: rtl/intr_stat_ctrl.sv
module intr_stat_ctrl
  import intr_stat_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  output strobe_t           st
);
  logic [2:0] addr3;

  assign addr3 = 3'(hostAddr);

  always_comb begin
    st = '0;
    st.rdSel     = addr3;
    st.intClrWr  = hostWe && (addr3 == A_ICLR);
    st.scsiClrWr = hostWe && (addr3 == A_SCLR);
    st.enWr      = hostWe && (addr3 == A_SEN);
  end
endmodule

// File: rtl/intr_stat_dp.sv
module intr_stat_dp
  import intr_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CODE_W = DATA_W - 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] scsiEvt,
  input  logic              cmdEvt,
  input  logic              brkEvt,
  input  logic              seqPost,
  input  logic [CODE_W-1:0] seqCodeIn,
  input  logic [DATA_W-1:0] hardEvt,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] scsiStat,
  output logic [DATA_W-1:0] hardErr,
  output logic              seqFlag,
  output logic [CODE_W-1:0] seqCode,
  output logic              intPending,
  output logic              irq
);
  logic [DATA_W-1:0] scsiEn;
  logic              cmdFlag;
  logic              brkFlag;
  logic              scsiInt;
  logic [DATA_W-1:0] scsiClrMask;
  logic [DATA_W-1:0] summary;

  assign scsiClrMask = st.scsiClrWr ? wdata : '0;
  assign scsiInt     = |(scsiStat & scsiEn);
  assign intPending  = brkFlag | seqFlag | scsiInt | cmdFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scsiStat <= '0;
      scsiEn   <= '0;
      hardErr  <= '0;
      cmdFlag  <= 1'b0;
      brkFlag  <= 1'b0;
      seqFlag  <= 1'b0;
      seqCode  <= '0;
      irq      <= 1'b0;
    end else begin
      // events are ORed in after the clear so they win a same-cycle clear
      scsiStat <= (scsiStat & ~scsiClrMask) | scsiEvt;
      if (st.enWr) scsiEn <= wdata;
      hardErr  <= hardErr | hardEvt;
      cmdFlag  <= (cmdFlag & ~(st.intClrWr & wdata[B_CMD])) | cmdEvt;
      brkFlag  <= (brkFlag & ~(st.intClrWr & wdata[B_BRK])) | brkEvt;
      if (seqPost) begin
        seqFlag <= 1'b1;
        seqCode <= seqCodeIn;
      end else if (st.intClrWr && wdata[B_SEQ]) begin
        seqFlag <= 1'b0;
        seqCode <= '0;
      end
      irq <= intPending | (|hardErr);
    end
  end

  always_comb begin
    summary = '0;
    summary[DATA_W-1:4] = seqCode;
    summary[B_BRK]  = brkFlag;
    summary[B_SCSI] = scsiInt;
    summary[B_CMD]  = cmdFlag;
    summary[B_SEQ]  = seqFlag;
  end

  always_comb begin
    case (st.rdSel)
      A_INT:   rdata = summary;
      A_SSTAT: rdata = scsiStat;
      A_SEN:   rdata = scsiEn;
      A_HERR:  rdata = hardErr;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/intr_stat_ctl.sv
module intr_stat_ctl
  import intr_stat_pkg::*;
#(
  parameter int DATA_W = intr_stat_pkg::DATA_W,
  parameter int ADDR_W = intr_stat_pkg::ADDR_W,
  localparam int CODE_W = DATA_W - 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic [DATA_W-1:0] scsiEvt,
  input  logic              cmdEvt,
  input  logic              brkEvt,
  input  logic              seqPost,
  input  logic [CODE_W-1:0] seqCodeIn,
  input  logic [DATA_W-1:0] hardEvt,
  output logic              intPending,
  output logic              irq
);
  strobe_t           st;
  logic [DATA_W-1:0] scsiStat;
  logic [DATA_W-1:0] hardErr;
  logic              seqFlag;
  logic [CODE_W-1:0] seqCode;

  intr_stat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .hostAddr(hostAddr), .hostWe(hostWe), .st(st)
  );

  intr_stat_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wdata(hostWdata),
    .scsiEvt(scsiEvt), .cmdEvt(cmdEvt), .brkEvt(brkEvt),
    .seqPost(seqPost), .seqCodeIn(seqCodeIn), .hardEvt(hardEvt),
    .rdata(hostRdata), .scsiStat(scsiStat), .hardErr(hardErr),
    .seqFlag(seqFlag), .seqCode(seqCode),
    .intPending(intPending), .irq(irq)
  );
endmodule

// File: rtl/intr_stat_chk.sv
module intr_stat_chk #(
  parameter int DATA_W = 8,
  localparam int CODE_W = DATA_W - 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] scsiEvt,
  input logic              seqPost,
  input logic              intPending,
  input logic              irq,
  input logic [DATA_W-1:0] scsiStat,
  input logic [DATA_W-1:0] hardErr,
  input logic              seqFlag,
  input logic [CODE_W-1:0] seqCode
);
  // R2
  scsi_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (scsiEvt != '0) |=> ((scsiStat & $past(scsiEvt)) == $past(scsiEvt)));

  // R7
  seq_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqPost |=> seqFlag);

  // R6
  code_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !seqFlag |-> (seqCode == '0));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    intPending |=> irq);

  // R9
  hard_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((hardErr & $past(hardErr)) == $past(hardErr)));

  // R9
  hard_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hardErr != '0) |=> irq);
endmodule

bind intr_stat_ctl intr_stat_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/intr_stat_ctl_bench.sv
module intr_stat_ctl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic       hostWe = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [7:0] scsiEvt = '0;
  logic       cmdEvt = 1'b0;
  logic       brkEvt = 1'b0;
  logic       seqPost = 1'b0;
  logic [3:0] seqCodeIn = '0;
  logic [7:0] hardEvt = '0;
  logic       intPending;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [2:0] R_INT = 3'd0, R_ICLR = 3'd1, R_SSTAT = 3'd2,
                         R_SCLR = 3'd3, R_SEN = 3'd4, R_HERR = 3'd5;

  // {enable, event, clear, expected status, expected irq}
  localparam logic [39:0] VEC [8] = '{
    {8'h00, 8'h05, 8'h00, 8'h05, 8'h00},
    {8'h01, 8'h05, 8'h00, 8'h05, 8'h01},
    {8'h02, 8'h05, 8'h00, 8'h05, 8'h00},
    {8'hFF, 8'h0C, 8'h04, 8'h08, 8'h01},
    {8'hFF, 8'h0C, 8'h0C, 8'h00, 8'h00},
    {8'h80, 8'h81, 8'h01, 8'h80, 8'h01},
    {8'h0F, 8'hF0, 8'h00, 8'hF0, 8'h00},
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  intr_stat_ctl u_intr_stat_ctl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .scsiEvt(scsiEvt),
    .cmdEvt(cmdEvt), .brkEvt(brkEvt), .seqPost(seqPost),
    .seqCodeIn(seqCodeIn), .hardEvt(hardEvt),
    .intPending(intPending), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    hostAddr = a;
    #1;
    d = hostRdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h1, 8'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    doReset();

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      hostRead(3'(a), rd);
      check("R1 reg after reset", rd, 8'h00);
    end
    check("R1 irq after reset", {7'b0, irq}, 8'h00);
    check("R1 pending after reset", {7'b0, intPending}, 8'h00);

    // R2 R3 R4 R8 vector table
    foreach (VEC[i]) begin
      hostWrite(R_SCLR, 8'hFF);
      hostWrite(R_SEN, VEC[i][39:32]);
      @(negedge clk); scsiEvt = VEC[i][31:24];
      @(negedge clk); scsiEvt = '0;
      hostWrite(R_SCLR, VEC[i][23:16]);
      tick();
      hostRead(R_SSTAT, rd);
      check("R2/R3 bus status", rd, VEC[i][15:8]);
      hostRead(R_SEN, rd);
      check("R4 enable readback", rd, VEC[i][39:32]);
      hostRead(R_INT, rd);
      check("R4 bus summary bit", {7'b0, rd[2]}, VEC[i][7:0]);
      check("R8 irq from bus", {7'b0, irq}, VEC[i][7:0]);
      hostRead(R_SCLR, rd);
      check("R3 clear reads zero", rd, 8'h00);
    end

    // R5 sequencer post
    @(negedge clk); seqPost = 1'b1; seqCodeIn = 4'h3;
    @(negedge clk); seqPost = 1'b0;
    hostRead(R_INT, rd);
    check("R5 seq code 3", rd, 8'h31);
    check("R8 pending seq", {7'b0, intPending}, 8'h01);
    tick();
    check("R8 irq seq", {7'b0, irq}, 8'h01);
    @(negedge clk); seqPost = 1'b1; seqCodeIn = 4'h0;
    @(negedge clk); seqPost = 1'b0;
    hostRead(R_INT, rd);
    check("R5 unknown phase code 0", rd, 8'h01);
    hostWrite(R_INT, 8'hF0);
    hostRead(R_INT, rd);
    check("R5 host write ignored", rd, 8'h01);

    // R6 clears
    hostWrite(R_ICLR, 8'h04);
    hostRead(R_INT, rd);
    check("R6 bit2 no effect", rd, 8'h01);
    hostWrite(R_ICLR, 8'h00);
    hostRead(R_INT, rd);
    check("R6 zero no effect", rd, 8'h01);
    @(negedge clk); seqPost = 1'b1; seqCodeIn = 4'h8;
    @(negedge clk); seqPost = 1'b0;
    hostWrite(R_ICLR, 8'h01);
    hostRead(R_INT, rd);
    check("R6 seq clear zeroes code", rd, 8'h00);
    tick();
    check("R8 irq drops", {7'b0, irq}, 8'h00);

    // R7 event beats same-cycle clear
    @(negedge clk);
    seqPost = 1'b1; seqCodeIn = 4'hE;
    hostAddr = R_ICLR; hostWdata = 8'h01; hostWe = 1'b1;
    @(negedge clk);
    seqPost = 1'b0; hostWe = 1'b0;
    hostRead(R_INT, rd);
    check("R7 seq post wins", rd, 8'hE1);
    hostWrite(R_ICLR, 8'h01);
    @(negedge clk);
    scsiEvt = 8'h02;
    hostAddr = R_SCLR; hostWdata = 8'hFF; hostWe = 1'b1;
    @(negedge clk);
    scsiEvt = '0; hostWe = 1'b0;
    hostRead(R_SSTAT, rd);
    check("R7 bus event wins", rd, 8'h02);
    hostWrite(R_SCLR, 8'hFF);
    @(negedge clk);
    cmdEvt = 1'b1;
    hostAddr = R_ICLR; hostWdata = 8'h02; hostWe = 1'b1;
    @(negedge clk);
    cmdEvt = 1'b0; hostWe = 1'b0;
    hostRead(R_INT, rd);
    check("R7 cmd event wins", rd, 8'h02);

    // R10 command complete and breakpoint
    @(negedge clk); brkEvt = 1'b1;
    @(negedge clk); brkEvt = 1'b0;
    hostRead(R_INT, rd);
    check("R10 cmd and brk", rd, 8'h0A);
    check("R8 pending cmd/brk", {7'b0, intPending}, 8'h01);
    hostWrite(R_ICLR, 8'h02);
    hostRead(R_INT, rd);
    check("R6 cmd cleared", rd, 8'h08);
    hostWrite(R_ICLR, 8'h08);
    hostRead(R_INT, rd);
    check("R6 brk cleared", rd, 8'h00);
    tick();
    check("R8 irq idle", {7'b0, irq}, 8'h00);

    // R9 hard errors
    @(negedge clk); hardEvt = 8'h20;
    @(negedge clk); hardEvt = 8'h00;
    hostRead(R_HERR, rd);
    check("R9 hard error set", rd, 8'h20);
    tick();
    check("R9 irq from hard error", {7'b0, irq}, 8'h01);
    hostWrite(R_ICLR, 8'hFF);
    hostWrite(R_SCLR, 8'hFF);
    hostWrite(R_HERR, 8'hFF);
    hostRead(R_HERR, rd);
    check("R9 not cleared by writes", rd, 8'h20);
    tick();
    check("R9 irq held", {7'b0, irq}, 8'h01);
    check("R9 pending excludes hard", {7'b0, intPending}, 8'h00);

    // R1 reset clears everything, including hard errors
    doReset();
    hostRead(R_HERR, rd);
    check("R1 hard error reset", rd, 8'h00);
    check("R1 irq reset", {7'b0, irq}, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule